// File: doc/BRIEF.md
# Error-Correcting RAM with Safety Diagnostics

This block is a single-port synchronous memory that keeps a check field beside every data word. A single-error-correct, double-error-detect Hamming code protects each word. Every write stores the data together with six position parity bits and one overall parity bit. Every read decodes the stored codeword. A flip of any one stored bit is repaired silently in the returned data. Two flipped bits are reported as uncorrectable, and the block never returns a miscorrected word for them.

Diagnostic logic runs beside the data path:

- Two saturating event counters, one for corrections and one for uncorrectable detections.
- Two sticky status flags.
- An alarm that rises when either count reaches a programmable threshold.
- A one-cycle reset request raised after every uncorrectable read.
- A fault-injection port that inverts one chosen bit of one stored codeword, so the correction path can be tested for latent faults.

Words never written since reset read as uncorrectable. An initialise sequence writes zero data with valid check bits into every location before normal use.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high, and a requester holds its request until it is accepted. `req_ready` is low while initialisation runs, and also in any cycle where `init_start` or `inj_valid` is high. The response side has no back-pressure: read data is presented for exactly one cycle.

Top module: `ecc_ram_diag`

## Requirements
- R1: After a single inverted bit in a stored codeword, the next read of that word returns the original data with `rsp_corrected` high and `rsp_uncorr` low. This holds for any of the 39 codeword bits.
- R2: After two distinct inverted bits in a stored codeword, the read response has `rsp_uncorr` high, `rsp_corrected` low and `rsp_rdata` zero.
- R3: A read request accepted on edge N presents `rsp_valid` high, with its data and flags, in the cycle after edge N, and only then. An accepted write produces no response. `req_ready` is low while `busy`, `init_start` or `inj_valid` is high.
- R4: `corr_count` and `det_count` each rise by one in the cycle after a corrected or uncorrectable response, respectively. Each stops at 2^CNT_W-1.
- R5: `status_clr` is write-one-to-clear, and a clear wins over an event in the same cycle. Bit 0 clears `corr_count`, bit 1 clears `det_count`, bit 2 clears the sticky `flag_corrected`, and bit 3 clears the sticky `flag_uncorr`. Each sticky flag is set in the cycle after a corrected or uncorrectable response, respectively.
- R6: `alarm` is high exactly when `alarm_thresh` is nonzero and either count is greater than or equal to it. A threshold of zero disables the alarm.
- R7: `inj_valid` inverts codeword bit `inj_bit` of word `inj_addr` when not busy and `init_start` is low. Bit 0 is the overall parity bit. Bit positions 1, 2, 4, 8, 16 and 32 hold the position parity bits. The remaining positions hold data bits 0 to 31 in ascending order. An index of 39 or more changes nothing, and injection is ignored while busy.
- R8: `reset_req` is high for one cycle, the cycle after each uncorrectable response.
- R9: A read of a location not written since reset returns zero data with `rsp_uncorr` high.
- R10: `init_start` while idle raises `busy` on the next edge for DEPTH cycles. During those cycles every location is written with zero data and valid check bits. `init_start` is ignored while busy.
- R11: A read of a correctly written, unmodified word returns the written data with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DW | Corrected read data |
| rsp_corrected | output | 1 | Response had a repaired single error |
| rsp_uncorr | output | 1 | Response is uncorrectable |
| init_start | input | 1 | Start initialise sequence |
| busy | output | 1 | Initialise sequence running |
| inj_valid | input | 1 | Apply one bit flip |
| inj_addr | input | AW | Word to disturb |
| inj_bit | input | IW | Codeword bit to invert |
| alarm_thresh | input | CNT_W | Alarm threshold, 0 disables |
| status_clr | input | 4 | Write-one-to-clear controls |
| corr_count | output | CNT_W | Corrected event count |
| det_count | output | CNT_W | Uncorrectable event count |
| flag_corrected | output | 1 | Sticky corrected flag |
| flag_uncorr | output | 1 | Sticky uncorrectable flag |
| alarm | output | 1 | Threshold alarm |
| reset_req | output | 1 | System reset request pulse |

## Verification
Read data and both flags are due in the cycle after the accepting edge. Counters, sticky flags and `reset_req` are due one cycle after that response. `req_ready`, `alarm` and `busy` follow from the current state with no added delay. A behavioural model in the bench tracks, for each address, the written data, a validity bit and the set of flipped bit positions. The model advances on the same rising edge as the design, and every output is compared against it at the falling edge that follows. This keeps each result checked in exactly the cycle it is due.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  // Number of position parity bits needed to cover dw data bits.
  function automatic int parity_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  typedef struct packed {
    logic corrected;
    logic uncorrectable;
  } ecc_flags_t;

endpackage

// File: rtl/secded_enc.sv
module secded_enc import ecc_ram_pkg::*; #(
  parameter int DW = 32,
  localparam int PB = parity_bits(DW),
  localparam int CW = DW + PB + 1
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code
);

  always_comb begin
    logic [CW-1:0] h;
    int j;
    h = '0;
    j = 0;
    // scatter data over the non-power-of-two positions
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_pow2(pos)) begin
        h[pos] = data[j];
        j++;
      end
    end
    // each check bit covers the positions that have its index bit set
    for (int i = 0; i < PB; i++) begin
      for (int pos = 1; pos < CW; pos++) begin
        if (pos[i] && !is_pow2(pos)) h[1 << i] = h[1 << i] ^ h[pos];
      end
    end
    h[0] = ^h[CW-1:1];
    code = h;
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec import ecc_ram_pkg::*; #(
  parameter int DW = 32,
  localparam int PB = parity_bits(DW),
  localparam int CW = DW + PB + 1
) (
  input  logic [CW-1:0] code,
  output logic [DW-1:0] data,
  output ecc_flags_t    flags
);

  always_comb begin
    logic [PB-1:0] syn;
    logic          odd;
    logic [CW-1:0] fixed;
    int            j;
    syn = '0;
    for (int i = 0; i < PB; i++) begin
      for (int pos = 1; pos < CW; pos++) begin
        if (pos[i]) syn[i] = syn[i] ^ code[pos];
      end
    end
    odd   = ^code;
    fixed = code;
    flags = '0;
    if (odd) begin
      // odd weight: one flip; syndrome 0 points at the overall bit
      if (int'(syn) < CW) begin
        fixed[syn]      = ~fixed[syn];
        flags.corrected = 1'b1;
      end else begin
        flags.uncorrectable = 1'b1;
      end
    end else if (syn != '0) begin
      flags.uncorrectable = 1'b1;
    end
    data = '0;
    j    = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if (!is_pow2(pos)) begin
        data[j] = fixed[pos];
        j++;
      end
    end
  end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int CW    = 39,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_start,
  input  logic [CW-1:0] init_code,
  input  logic          inj_valid,
  input  logic [AW-1:0] inj_addr,
  input  logic [IW-1:0] inj_bit,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] wr_code,
  output logic          req_ready,
  output logic          busy,
  output logic          rd_fire,
  output logic          rd_known,
  output logic [CW-1:0] rd_code
);

  logic [CW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [AW-1:0]    init_idx;
  logic [CW-1:0]    flip_mask;
  logic             take;
  logic             do_inj;

  assign req_ready = !busy && !init_start && !inj_valid;
  assign take      = req_valid && req_ready;
  assign do_inj    = inj_valid && !busy && !init_start;
  assign flip_mask = {{(CW-1){1'b0}}, 1'b1} << inj_bit;

  // array port: init, injection and requests are mutually exclusive
  always_ff @(posedge clk) begin
    if (busy)
      mem[init_idx] <= init_code;
    else if (do_inj)
      mem[inj_addr] <= mem[inj_addr] ^ flip_mask;
    else if (take && req_write)
      mem[req_addr] <= wr_code;
    if (take && !req_write)
      rd_code <= mem[req_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      init_idx <= '0;
      written  <= '0;
      rd_fire  <= 1'b0;
      rd_known <= 1'b0;
    end else begin
      rd_fire <= take && !req_write;
      if (take && !req_write)
        rd_known <= written[req_addr];
      if (busy) begin
        written[init_idx] <= 1'b1;
        init_idx          <= init_idx + 1'b1;
        if (init_idx == AW'(DEPTH - 1))
          busy <= 1'b0;
      end else if (init_start) begin
        busy     <= 1'b1;
        init_idx <= '0;
      end else if (take && req_write) begin
        written[req_addr] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_diag.sv
module ecc_diag #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_corr,
  input  logic             ev_unc,
  input  logic [3:0]       clr,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] corr_count,
  output logic [CNT_W-1:0] det_count,
  output logic             flag_corrected,
  output logic             flag_uncorr,
  output logic             alarm,
  output logic             reset_req
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [2];
  logic [1:0]       ev;
  logic [1:0]       sticky;

  assign ev = {ev_unc, ev_corr};

  for (genvar k = 0; k < 2; k++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[k]  <= '0;
        sticky[k] <= 1'b0;
      end else begin
        if (clr[k])
          cnt_q[k] <= '0;
        else if (ev[k] && cnt_q[k] != CMAX)
          cnt_q[k] <= cnt_q[k] + 1'b1;
        if (clr[k+2])
          sticky[k] <= 1'b0;
        else if (ev[k])
          sticky[k] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= ev_unc;
  end

  assign corr_count     = cnt_q[0];
  assign det_count      = cnt_q[1];
  assign flag_corrected = sticky[0];
  assign flag_uncorr    = sticky[1];
  assign alarm = (thresh != '0) && (cnt_q[0] >= thresh || cnt_q[1] >= thresh);

endmodule

// File: rtl/ecc_ram_diag.sv
module ecc_ram_diag import ecc_ram_pkg::*; #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PB   = parity_bits(DW),
  localparam int CW   = DW + PB + 1,
  localparam int IW   = $clog2(CW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_corrected,
  output logic             rsp_uncorr,
  input  logic             init_start,
  output logic             busy,
  input  logic             inj_valid,
  input  logic [AW-1:0]    inj_addr,
  input  logic [IW-1:0]    inj_bit,
  input  logic [CNT_W-1:0] alarm_thresh,
  input  logic [3:0]       status_clr,
  output logic [CNT_W-1:0] corr_count,
  output logic [CNT_W-1:0] det_count,
  output logic             flag_corrected,
  output logic             flag_uncorr,
  output logic             alarm,
  output logic             reset_req
);

  logic [CW-1:0] wr_code, zero_code, rd_code;
  logic [DW-1:0] dec_data;
  ecc_flags_t    dec_flags;
  logic          rd_fire, rd_known;

  secded_enc #(.DW(DW)) u_enc_wr   (.data(req_wdata), .code(wr_code));
  secded_enc #(.DW(DW)) u_enc_zero (.data('0),        .code(zero_code));

  ecc_store #(.CW(CW), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .init_start, .init_code(zero_code),
    .inj_valid, .inj_addr, .inj_bit,
    .req_valid, .req_write, .req_addr, .wr_code,
    .req_ready, .busy, .rd_fire, .rd_known, .rd_code
  );

  secded_dec #(.DW(DW)) u_dec (.code(rd_code), .data(dec_data), .flags(dec_flags));

  assign rsp_valid     = rd_fire;
  assign rsp_corrected = rd_fire && rd_known && dec_flags.corrected;
  assign rsp_uncorr    = rd_fire && (!rd_known || dec_flags.uncorrectable);
  assign rsp_rdata     = (rd_fire && rd_known && !dec_flags.uncorrectable) ? dec_data : '0;

  ecc_diag #(.CNT_W(CNT_W)) u_diag (
    .clk, .rst_n,
    .ev_corr(rsp_corrected), .ev_unc(rsp_uncorr),
    .clr(status_clr), .thresh(alarm_thresh),
    .corr_count, .det_count, .flag_corrected, .flag_uncorr, .alarm, .reset_req
  );

endmodule

// File: rtl/ecc_ram_diag_chk.sv
module ecc_ram_diag_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_corrected,
  input logic             rsp_uncorr,
  input logic             busy,
  input logic [3:0]       status_clr,
  input logic [CNT_W-1:0] corr_count,
  input logic             reset_req
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_rsp_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_rsp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_corrected && rsp_uncorr));

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncorr) |=> reset_req);

  p_count_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_count == CMAX && !status_clr[0]) |=> corr_count == CMAX);

  p_count_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr[0] |=> corr_count == '0);

endmodule

bind ecc_ram_diag ecc_ram_diag_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_corrected(rsp_corrected),
  .rsp_uncorr(rsp_uncorr), .busy(busy), .status_clr(status_clr),
  .corr_count(corr_count), .reset_req(reset_req)
);

// File: tb/tb_ecc_ram_diag.sv
module tb_ecc_ram_diag;
  localparam int DW = 32, DEPTH = 64, CNT_W = 8, AW = 6, CW = 39, IW = 6;
  localparam int CMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, init_start = 0, inj_valid = 0;
  logic [AW-1:0] req_addr = '0, inj_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [IW-1:0] inj_bit = '0;
  logic [CNT_W-1:0] alarm_thresh = '0;
  logic [3:0] status_clr = '0;
  logic req_ready, rsp_valid, rsp_corrected, rsp_uncorr, busy;
  logic flag_corrected, flag_uncorr, alarm, reset_req;
  logic [DW-1:0] rsp_rdata;
  logic [CNT_W-1:0] corr_count, det_count;

  int ncmp = 0, nfail = 0;

  always #5 clk = ~clk;

  ecc_ram_diag dut (.*);

  // ---------- behavioural reference ----------
  bit          m_valid [DEPTH];
  logic [31:0] m_data  [DEPTH];
  logic [38:0] m_flip  [DEPTH];
  bit m_busy, m_rv, m_rc, m_ru, m_fc, m_fu, m_rr;
  int m_idx, m_cc, m_dc;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) begin m_valid[i] = 0; m_flip[i] = '0; m_data[i] = '0; end
      m_busy = 0; m_idx = 0; m_rv = 0; m_rc = 0; m_ru = 0;
      m_fc = 0; m_fu = 0; m_rr = 0; m_cc = 0; m_dc = 0; m_rd = '0;
    end else begin
      bit ec, eu;
      ec = m_rv && m_rc; eu = m_rv && m_ru;
      if (status_clr[0]) m_cc = 0; else if (ec && m_cc < CMAX) m_cc++;
      if (status_clr[1]) m_dc = 0; else if (eu && m_dc < CMAX) m_dc++;
      if (status_clr[2]) m_fc = 0; else if (ec) m_fc = 1;
      if (status_clr[3]) m_fu = 0; else if (eu) m_fu = 1;
      m_rr = eu;
      m_rv = 0; m_rc = 0; m_ru = 0; m_rd = '0;
      if (m_busy) begin
        m_valid[m_idx] = 1; m_data[m_idx] = '0; m_flip[m_idx] = '0;
        m_idx++;
        if (m_idx == DEPTH) m_busy = 0;
      end else if (init_start) begin
        m_busy = 1; m_idx = 0;
      end else if (inj_valid) begin
        if (int'(inj_bit) < CW) m_flip[inj_addr][inj_bit] = ~m_flip[inj_addr][inj_bit];
      end else if (req_valid) begin
        if (req_write) begin
          m_valid[req_addr] = 1; m_data[req_addr] = req_wdata; m_flip[req_addr] = '0;
        end else begin
          m_rv = 1;
          if (!m_valid[req_addr]) m_ru = 1;
          else if ($countones(m_flip[req_addr]) == 0) m_rd = m_data[req_addr];
          else if ($countones(m_flip[req_addr]) == 1) begin m_rc = 1; m_rd = m_data[req_addr]; end
          else m_ru = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    ncmp++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit m_alarm;
    m_alarm = (alarm_thresh != 0) && (m_cc >= int'(alarm_thresh) || m_dc >= int'(alarm_thresh));
    chk("R3 req_ready", req_ready, !m_busy && !init_start && !inj_valid);
    chk("R10 busy", busy, m_busy);
    chk("R3 rsp_valid", rsp_valid, m_rv);
    chk("R1 R11 rsp_rdata", rsp_rdata, m_rd);
    chk("R1 R7 rsp_corrected", rsp_corrected, m_rc);
    chk("R2 R9 rsp_uncorr", rsp_uncorr, m_ru);
    chk("R4 corr_count", corr_count, m_cc);
    chk("R4 det_count", det_count, m_dc);
    chk("R5 flag_corrected", flag_corrected, m_fc);
    chk("R5 flag_uncorr", flag_uncorr, m_fu);
    chk("R6 alarm", alarm, m_alarm);
    chk("R8 reset_req", reset_req, m_rr);
  end

  // ---------- stimulus ----------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; init_start = 0; inj_valid = 0; status_clr = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
    step(); idle();
  endtask

  task automatic rd(input int a);
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    step(); idle();
  endtask

  task automatic inj(input int a, input int b);
    inj_valid = 1; inj_addr = AW'(a); inj_bit = IW'(b);
    step(); idle();
  endtask

  task automatic clr(input logic [3:0] m);
    status_clr = m; step(); idle();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R9: never-written word
    rd(3); step(); step();
    // R11: clean patterns
    wr(0, 32'h0); wr(63, 32'hFFFF_FFFF); wr(1, 32'h1); wr(2, 32'h8000_0000); wr(7, 32'hDEAD_BEEF);
    rd(0); rd(63); rd(1); rd(2); rd(7); step();
    // R1 R7: single flips across all codeword bits
    for (int b = 0; b < CW; b++) begin
      wr(9, 32'hA5A5_0000 ^ (b * 32'h0101_0101));
      inj(9, b);
      rd(9);
    end
    // R7: out-of-range index changes nothing
    wr(10, 32'h1234_5678); inj(10, 45); rd(10);
    // R2 R8: double flips
    wr(11, 32'hCAFE_F00D); inj(11, 3); inj(11, 20); rd(11); step(); step();
    wr(12, 32'h0F0F_0F0F); inj(12, 0); inj(12, 38); rd(12); step();
    // R5: clears, including clear in the same cycle as an event
    clr(4'hF);
    wr(13, 32'h55); inj(13, 5); rd(13);
    status_clr = 4'b0101; step(); idle();
    step();
    // R6 R4: threshold alarm and saturation with a held request
    alarm_thresh = 8'd10;
    wr(5, 32'h0BAD_C0DE); inj(5, 7);
    req_valid = 1; req_write = 0; req_addr = AW'(5);
    repeat (300) step();
    idle(); step(); step();
    alarm_thresh = 8'd0; step();
    clr(4'b0001); step();
    // R10: initialise, with injection and restart attempts while busy
    init_start = 1; step(); idle();
    repeat (10) step();
    inj(0, 4);
    init_start = 1; step(); idle();
    req_valid = 1; req_write = 0; req_addr = AW'(2);
    while (busy) step();
    step(); idle();
    rd(0); rd(3); rd(63); step();
    // R3: back-to-back reads and a write without response
    req_valid = 1; req_write = 0; req_addr = AW'(7); step();
    req_addr = AW'(8); step();
    req_write = 1; req_wdata = 32'h7777_0000; step(); idle();
    rd(8); step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end

endmodule